// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the device-side front end of a NAND flash memory. Each byte
accepted on the 8-bit input stream is classified as a command byte, an
address byte, or both, from the chip-enable (active low), command-latch and
address-latch pins. The block turns command opcodes into internal operations.
It assembles multi-byte addresses least significant byte first. It issues
single-cycle action pulses that tell a downstream page engine what to do. The
status register and the write-protect view are kept here as well.

Two device classes are handled by the `large_page` pin. Small-page parts
(512-byte pages) trigger reads and program loads after three address bytes.
Large-page parts (2048-byte pages) trigger them after four. Large-page parts
also accept a random-read sequence and ignore a read confirm that follows a
read. The two alternative read opcodes fold into a plain read with a preset
column offset. The input stream never back-pressures: `in_ready` is always
high, and a byte is taken on every clock edge where `in_valid` is high.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is a command only when `ce_n`=0 and `cle`=1; with `ce_n`=1 a `cle` byte leaves `cur_cmd` unchanged and issues nothing. A byte is an address byte whenever `ale`=1, regardless of `ce_n`.
- R2: Address bytes fill `act_addr` bits [7:0], [15:8], [23:16], [31:24] in arrival order. `addr_count` clears on every accepted command except random-read confirm 0xE0.
- R3: After opcode 0x90, the first address byte issues a READ_ID action (kind 5).
- R4: With current command 0x00 (or 0x80), the third address byte (small page) or the fourth (large page) issues READ kind 1 (or PROG_LOAD kind 2) with the collected address.
- R5: Opcode 0x01 sets `cur_cmd` to 0x00 with column offset 0x100. Opcode 0x50 sets it to 0x00 with offset 512 (small) or 2048 (large). Opcode 0x00 clears the offset. The offset is reported in `act_col` on the READ and then cleared.
- R6: On large-page parts, 0x30 while `cur_cmd` is 0x00 is ignored completely. 0x05 clears address bits [15:0] and `addr_count` without changing `cur_cmd`.
- R7: These opcodes act on the byte itself: 0x70 gives STATUS (kind 6); 0xE0 gives RAND_READ (kind 8, large page only); 0xFF gives RESET (kind 7).
- R8: `status_q[7]` follows `wp_n` one cycle later. `eng_status_set[i]` sets `status_q[i]` sticky for bits 0..6.
- R9: Opcode 0xFF sets `cur_cmd` to 0x00 and clears the address, `addr_count`, the offset and `status_q[6:0]`, keeping bit 7.
- R10: Opcode 0xD0 shifts the address left by 8 (small) or 16 (large) and issues ERASE (kind 4) with the shifted address. Opcode 0x10 issues PROG_COMMIT (kind 3). Neither is issued while `wp_n`=0.
- R11: An opcode outside {00,01,05,10,30,50,60,70,80,90,D0,E0,FF} is latched into `cur_cmd`, issues nothing, and sets `unknown_seen` until `rst_n` falls.
- R12: `act_valid` is high for exactly one cycle, in the cycle after the accepted byte, and never follows a cycle without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| large_page | input | 1 | 1 selects large-page device class |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| in_valid | input | 1 | Byte strobe on the input stream |
| in_ready | output | 1 | Always 1: no back-pressure |
| in_data | input | 8 | Input byte |
| eng_status_set | input | 7 | Sticky set mask for status bits 0..6 |
| act_valid | output | 1 | One-cycle action pulse |
| act_kind | output | 4 | Action code (1 READ … 8 RAND_READ) |
| act_addr | output | 32 | Address carried with the action |
| act_col | output | 12 | Column offset carried with the action |
| cur_cmd | output | 8 | Currently latched command |
| addr_count | output | 3 | Address bytes collected (saturates at 7) |
| status_q | output | 8 | Status register |
| unknown_seen | output | 1 | Sticky unknown-opcode flag |

## Verification
The bound checker watches, on every cycle, the properties that hold across any byte sequence. A byte with `ce_n` high never moves the latched command. Erase and program commit never appear while write protect was asserted. Status bit 7 tracks the pin, a reset action leaves a cleared state, the unknown flag stays set, and no pulse appears without a strobe. The bench scenarios are the only way to show the values themselves. These include the byte-order assembly of addresses, the three- versus four-byte trigger point, the folded read offsets, the large-page 0x30 and 0x05 handling, and the erase shift amounts.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_READ_HALF = 8'h01;
  localparam logic [7:0] OP_READ_OOB  = 8'h50;
  localparam logic [7:0] OP_LP_CONF   = 8'h30;
  localparam logic [7:0] OP_RND_SETUP = 8'h05;
  localparam logic [7:0] OP_RND_CONF  = 8'hE0;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_PROG_SET  = 8'h80;
  localparam logic [7:0] OP_PROG_CONF = 8'h10;
  localparam logic [7:0] OP_ERASE_SET = 8'h60;
  localparam logic [7:0] OP_ERASE_CNF = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;

  typedef enum logic [3:0] {
    ACT_NONE        = 4'd0,
    ACT_READ        = 4'd1,
    ACT_PROG_LOAD   = 4'd2,
    ACT_PROG_COMMIT = 4'd3,
    ACT_ERASE       = 4'd4,
    ACT_READ_ID     = 4'd5,
    ACT_STATUS      = 4'd6,
    ACT_RESET       = 4'd7,
    ACT_RAND_READ   = 4'd8
  } act_kind_e;

  typedef enum logic [1:0] {
    FOLD_KEEP  = 2'd0,
    FOLD_ZERO  = 2'd1,
    FOLD_HALF  = 2'd2,
    FOLD_SPARE = 2'd3
  } fold_e;

endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
  import nand_fe_pkg::*;
(
  input  logic [7:0] op_in,
  output logic [7:0] op_mapped,
  output fold_e      fold,
  output logic       known
);

  always_comb begin
    op_mapped = op_in;
    fold      = FOLD_KEEP;
    known     = 1'b1;
    unique case (op_in)
      OP_READ:      fold = FOLD_ZERO;
      OP_READ_HALF: begin fold = FOLD_HALF;  op_mapped = OP_READ; end
      OP_READ_OOB:  begin fold = FOLD_SPARE; op_mapped = OP_READ; end
      OP_LP_CONF, OP_RND_SETUP, OP_RND_CONF, OP_IDENT, OP_RESET,
      OP_PROG_SET, OP_PROG_CONF, OP_ERASE_SET, OP_ERASE_CNF,
      OP_STATUS:    known = 1'b1;
      default:      known = 1'b0;
    endcase
  end

endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg #(
  parameter int FLAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic [FLAG_W-1:0] set_mask,
  input  logic              clr,
  output logic [FLAG_W:0]   status
);

  logic [FLAG_W-1:0] flags_q;
  logic              unprot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      unprot_q <= 1'b0;
    end else begin
      unprot_q <= wp_n;
      if (clr) flags_q <= '0;
      else     flags_q <= flags_q | set_mask;
    end
  end

  assign status = {unprot_q, flags_q};

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SMALL = 512,
  parameter int PAGE_LARGE = 2048,
  parameter int HALF_OFF   = 256,
  parameter int SP_BYTES   = 3,
  parameter int LP_BYTES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              large_page,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              wp_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [6:0]        eng_status_set,
  output logic              act_valid,
  output logic [3:0]        act_kind,
  output logic [ADDR_W-1:0] act_addr,
  output logic [11:0]       act_col,
  output logic [7:0]        cur_cmd,
  output logic [2:0]        addr_count,
  output logic [7:0]        status_q,
  output logic              unknown_seen
);

  localparam int NBYTES = ADDR_W / 8;
  localparam int CW     = 3;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [11:0] OFF_HALF = 12'(HALF_OFF);
  localparam logic [11:0] OFF_SP   = 12'(PAGE_SMALL);
  localparam logic [11:0] OFF_LP   = 12'(PAGE_LARGE);

  logic [7:0]        cmd_q, n_cmd;
  logic [ADDR_W-1:0] addr_q, n_addr;
  logic [CW-1:0]     cnt_q, n_cnt;
  logic [11:0]       off_q, n_off, n_col;
  act_kind_e         n_act;
  logic              n_unk, sts_clr;
  logic              act_v_q;
  act_kind_e         act_k_q;
  logic [ADDR_W-1:0] act_a_q;
  logic [11:0]       act_c_q;
  logic              unk_q;

  logic [7:0] op_mapped;
  fold_e      op_fold;
  logic       op_known;

  nand_op_decode u_dec (
    .op_in     (in_data),
    .op_mapped (op_mapped),
    .fold      (op_fold),
    .known     (op_known)
  );

  nand_status_reg #(.FLAG_W(7)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .set_mask (eng_status_set),
    .clr      (sts_clr),
    .status   (status_q)
  );

  logic cmd_byte, addr_byte;
  assign cmd_byte  = in_valid && !ce_n && cle;
  assign addr_byte = in_valid && ale;

  always_comb begin
    logic skip;
    logic [CW-1:0] trig;
    n_cmd   = cmd_q;
    n_addr  = addr_q;
    n_cnt   = cnt_q;
    n_off   = off_q;
    n_col   = off_q;
    n_act   = ACT_NONE;
    n_unk   = 1'b0;
    sts_clr = 1'b0;
    skip    = 1'b0;
    trig    = large_page ? CW'(LP_BYTES) : CW'(SP_BYTES);

    if (cmd_byte) begin
      if (large_page && cmd_q == OP_READ && in_data == OP_LP_CONF) begin
        skip = 1'b1;
      end else if (large_page && in_data == OP_RND_SETUP) begin
        n_addr[15:0] = '0;
        n_cnt        = '0;
        skip         = 1'b1;
      end else begin
        unique case (op_fold)
          FOLD_ZERO:  n_off = '0;
          FOLD_HALF:  n_off = OFF_HALF;
          FOLD_SPARE: n_off = large_page ? OFF_LP : OFF_SP;
          default:    ;
        endcase
        n_cmd = op_mapped;
        n_unk = !op_known;
        n_col = n_off;
        case (op_mapped)
          OP_STATUS: n_act = ACT_STATUS;
          OP_PROG_CONF: begin
            if (wp_n) begin
              n_act = ACT_PROG_COMMIT;
              n_off = '0;
            end
          end
          OP_ERASE_CNF: begin
            n_addr = large_page ? (addr_q << 16) : (addr_q << 8);
            if (wp_n) n_act = ACT_ERASE;
          end
          OP_RND_CONF: begin
            if (large_page) n_act = ACT_RAND_READ;
          end
          OP_RESET: begin
            n_act   = ACT_RESET;
            n_cmd   = OP_READ;
            n_addr  = '0;
            n_off   = '0;
            n_col   = '0;
            sts_clr = 1'b1;
          end
          default: ;
        endcase
        if (op_mapped != OP_RND_CONF) n_cnt = '0;
      end
    end

    if (addr_byte && !skip) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (int'(n_cnt) == b) n_addr[8*b +: 8] = in_data;
      end
      if (n_cnt != CNT_MAX) n_cnt = n_cnt + 1'b1;
      if (n_cnt == CW'(1) && n_cmd == OP_IDENT) begin
        n_act = ACT_READ_ID;
        n_col = n_off;
      end
      if (n_cnt == trig && n_cmd == OP_READ) begin
        n_act = ACT_READ;
        n_col = n_off;
        n_off = '0;
      end
      if (n_cnt == trig && n_cmd == OP_PROG_SET) begin
        n_act = ACT_PROG_LOAD;
        n_col = n_off;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= OP_READ;
      addr_q  <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      act_v_q <= 1'b0;
      act_k_q <= ACT_NONE;
      act_a_q <= '0;
      act_c_q <= '0;
      unk_q   <= 1'b0;
    end else begin
      cmd_q   <= n_cmd;
      addr_q  <= n_addr;
      cnt_q   <= n_cnt;
      off_q   <= n_off;
      act_v_q <= (n_act != ACT_NONE);
      act_k_q <= n_act;
      act_a_q <= n_addr;
      act_c_q <= n_col;
      unk_q   <= unk_q | n_unk;
    end
  end

  assign in_ready     = 1'b1;
  assign act_valid    = act_v_q;
  assign act_kind     = act_k_q;
  assign act_addr     = act_a_q;
  assign act_col      = act_c_q;
  assign cur_cmd      = cmd_q;
  assign addr_count   = cnt_q;
  assign unknown_seen = unk_q;

endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       wp_n,
  input logic       in_valid,
  input logic       act_valid,
  input logic [3:0] act_kind,
  input logic [7:0] cur_cmd,
  input logic [2:0] addr_count,
  input logic [7:0] status_q,
  input logic       unknown_seen
);

  logic warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  a_r1_ce_gates_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(in_valid && ce_n) |-> cur_cmd == $past(cur_cmd));

  a_r8_wp_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> status_q[7] == $past(wp_n));

  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_kind == 4'd7 |->
      status_q[6:0] == 7'd0 && cur_cmd == 8'h00 && addr_count == 3'd0);

  a_r10_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    warm && act_valid && (act_kind == 4'd4 || act_kind == 4'd3) |-> $past(wp_n));

  a_r11_unknown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(unknown_seen) |-> unknown_seen);

  a_r12_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !$past(in_valid) |-> !act_valid);

  a_r12_kind_valid: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> act_kind != 4'd0 && act_kind <= 4'd8);

endmodule

bind nand_cmd_front nand_cmd_front_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_n         (ce_n),
  .wp_n         (wp_n),
  .in_valid     (in_valid),
  .act_valid    (act_valid),
  .act_kind     (act_kind),
  .cur_cmd      (cur_cmd),
  .addr_count   (addr_count),
  .status_q     (status_q),
  .unknown_seen (unknown_seen)
);

// File: tb/nand_cmd_front_tb.sv
`timescale 1ns/1ps
module nand_cmd_front_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        large_page = 1'b0;
  logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [6:0]  eng_status_set = 7'd0;
  logic        in_ready, act_valid, unknown_seen;
  logic [3:0]  act_kind;
  logic [31:0] act_addr;
  logic [11:0] act_col;
  logic [7:0]  cur_cmd, status_q;
  logic [2:0]  addr_count;

  always #5 clk = ~clk;

  nand_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .large_page(large_page), .ce_n(ce_n),
    .cle(cle), .ale(ale), .wp_n(wp_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .eng_status_set(eng_status_set),
    .act_valid(act_valid), .act_kind(act_kind), .act_addr(act_addr),
    .act_col(act_col), .cur_cmd(cur_cmd), .addr_count(addr_count),
    .status_q(status_q), .unknown_seen(unknown_seen)
  );

  int n_chk = 0, n_bad = 0;
  logic [47:0] exp_q[$];
  string exp_tag[$];
  logic done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_act(string tag, logic [3:0] k, logic [31:0] a, logic [11:0] c);
    exp_q.push_back({k, a, c});
    exp_tag.push_back(tag);
  endtask

  // monitor: pops the scoreboard for every pulse
  always @(negedge clk) begin
    if (rst_n && act_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected pulse actual=%h expected=none",
                 {act_kind, act_addr, act_col});
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        if ({act_kind, act_addr, act_col} !== e) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", t,
                   {act_kind, act_addr, act_col}, e);
        end
      end
    end
  end

  task automatic send(logic [7:0] d, logic c, logic a, logic ce);
    @(negedge clk);
    in_data = d; cle = c; ale = a; ce_n = ce; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
  endtask

  task automatic cmd(logic [7:0] d);  send(d, 1'b1, 1'b0, 1'b0); endtask
  task automatic adr(logic [7:0] d);  send(d, 1'b0, 1'b1, 1'b0); endtask

  task automatic drain(string tag);
    @(negedge clk);
    chk(tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    chk("R9 reset cur_cmd", cur_cmd, 8'h00);
    chk("R9 reset count", addr_count, 0);
    chk("R8 reset status", status_q, 8'h80);
    chk("R11 reset unknown", unknown_seen, 0);
    chk("R12 ready", in_ready, 1);

    // small page reads
    cmd(8'h00); adr(8'h11); adr(8'h22);
    chk("R4 no early trigger", addr_count, 2);
    expect_act("R4 R2 small read", 4'd1, 32'h0033_2211, 12'h000);
    adr(8'h33);
    chk("R2 count three", addr_count, 3);
    cmd(8'h01);
    chk("R5 half folds to read", cur_cmd, 8'h00);
    adr(8'hAA); adr(8'hBB);
    expect_act("R5 half offset", 4'd1, 32'h00CC_BBAA, 12'h100);
    adr(8'hCC);
    cmd(8'h50); adr(8'h01); adr(8'h02);
    expect_act("R5 spare offset small", 4'd1, 32'h0003_0201, 12'd512);
    adr(8'h03);
    cmd(8'h90);
    expect_act("R3 read id", 4'd5, 32'h0003_0200, 12'h000);
    adr(8'h00);
    expect_act("R7 status", 4'd6, 32'h0003_0200, 12'h000);
    cmd(8'h70);
    // ce_n high: command ignored
    send(8'h90, 1'b1, 1'b0, 1'b1);
    chk("R1 ce_n high ignored", cur_cmd, 8'h70);
    // erase small
    cmd(8'h60); adr(8'h12); adr(8'h34);
    chk("R2 count after erase setup", addr_count, 2);
    expect_act("R10 erase small shift", 4'd4, 32'h0334_1200, 12'h000);
    cmd(8'hD0);
    // program
    cmd(8'h80); adr(8'h05); adr(8'h06);
    expect_act("R4 program load", 4'd2, 32'h0307_0605, 12'h000);
    adr(8'h07);
    expect_act("R10 program commit", 4'd3, 32'h0307_0605, 12'h000);
    cmd(8'h10);
    // write protect
    @(negedge clk); wp_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 wp low clears bit7", status_q, 8'h00);
    cmd(8'h10); cmd(8'h60); cmd(8'hD0);
    drain("R10 protected no pulse");
    wp_n = 1'b1;
    // unknown opcode
    cmd(8'hAB);
    chk("R11 unknown latched", cur_cmd, 8'hAB);
    chk("R11 unknown flag", unknown_seen, 1);
    drain("R11 unknown no pulse");
    // engine flags, then reset
    @(negedge clk); eng_status_set = 7'h05;
    @(negedge clk); eng_status_set = 7'h00;
    chk("R8 engine flags", status_q, 8'h85);
    expect_act("R9 reset pulse", 4'd7, 32'h0, 12'h000);
    cmd(8'hFF);
    chk("R9 status keeps bit7", status_q, 8'h80);
    chk("R9 cmd back to read", cur_cmd, 8'h00);
    chk("R11 flag stays", unknown_seen, 1);

    // large page
    large_page = 1'b1;
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
    chk("R4 large no trigger at 3", addr_count, 3);
    expect_act("R4 large read", 4'd1, 32'h0403_0201, 12'h000);
    adr(8'h04);
    cmd(8'h30);
    chk("R6 confirm ignored cmd", cur_cmd, 8'h00);
    chk("R6 confirm ignored count", addr_count, 4);
    cmd(8'h05);
    chk("R6 random setup count", addr_count, 0);
    chk("R6 random setup cmd", cur_cmd, 8'h00);
    adr(8'h44); adr(8'h55);
    expect_act("R7 random read", 4'd8, 32'h0403_5544, 12'h000);
    cmd(8'hE0);
    chk("R2 E0 keeps count", addr_count, 2);
    cmd(8'h50); adr(8'h00); adr(8'h00); adr(8'h00);
    expect_act("R5 spare offset large", 4'd1, 32'h0, 12'd2048);
    adr(8'h00);
    cmd(8'h60); adr(8'h21); adr(8'h43); adr(8'h65);
    expect_act("R10 erase large shift", 4'd4, 32'h4321_0000, 12'h000);
    cmd(8'hD0);
    cmd(8'h90);
    expect_act("R1 ale with ce_n high", 4'd5, 32'h4321_00EC, 12'h000);
    send(8'hEC, 1'b0, 1'b1, 1'b1);
    drain("R12 all pulses seen");
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule